// File: doc/BRIEF.md
# SPI Test-Mode Pin Controller

This block sits between the serial shift engine of an SPI port and the pad ring. In normal operation it is transparent: the shifter's data output and clock go straight to the pads, and the pad's data input goes straight to the shifter. One 32-bit control/status register lets software enter a test mode. In that mode the outgoing data line is looped back internally onto the incoming data line, and the clock pad is driven from a software bit. The data output can optionally be pinned to a second software bit instead of the shifter.

While test mode is on, the register also reports the live levels of the incoming data line, the clock line and the chip-select enable lines. Each of these passes through a two-stage synchronizer first. While test mode is off, the register reads as all zeros. Writes are accepted in both modes.

Top module: `spi_testmode_ctl`

## Requirements
- R1: After reset all writable bits are 0, the register reads 0x00000000, and the pins pass the functional signals through.
- R2: While the test-enable bit (bit 0) is 0, every read returns 0, whatever was written to the other bits.
- R3: While test mode is off, pad_sdo equals func_sdo, pad_sclk equals func_sclk and core_sdi equals pin_sdi. The force bit (bit 1) has no effect in this mode.
- R4: While test mode is on, core_sdi equals pad_sdo (internal loopback), and pin_sdi has no effect.
- R5: While test mode is on, pad_sdo takes the value of bit 2 when bit 1 is 1, and follows func_sdo when bit 1 is 0.
- R6: While test mode is on, pad_sclk takes the value of bit 4.
- R7: While test mode is on, bit 3 reads the core_sdi level sampled two clock edges earlier. Bit 5 reads the pad_sclk level sampled two edges earlier, and bits 10:6 read pin_cs (bit 6 = pin_cs[0]) sampled two edges earlier. All synchronizer stages reset to 0.
- R8: While test mode is on, bits 31:11 read 0 and bits 0, 1, 2 and 4 read back the last value written. Write data on bits 3, 5 and 10:6 is ignored.
- R9: A write takes effect on the clock edge at which reg_wr is sampled high. The register contents and the pins change after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| func_sdo | input | 1 | Data output from the shift engine |
| func_sclk | input | 1 | Serial clock from the shift engine |
| core_sdi | output | 1 | Data input delivered to the shift engine |
| pin_sdi | input | 1 | Data input from the pad |
| pin_cs | input | NCS | Chip-select enable lines |
| pad_sdo | output | 1 | Data output to the pad |
| pad_sclk | output | 1 | Serial clock to the pad |

## Verification
The hardest situation to reach is a status read that shows the two-cycle synchronizer delay while the loopback source changes underneath it. In that situation bit 3 follows the looped-back pad_sdo, which itself switches between func_sdo and the software bit as the force bit toggles. The stimulus enables test mode and then issues random register writes on random cycles while func_sdo, func_sclk, pin_sdi and pin_cs change every cycle. A cycle-level reference model checks every status bit against its history two edges back. Stretches with test mode off, in which the force and value bits are set, confirm that those bits have no effect there.

// File: rtl/spi_tm_pkg.sv
package spi_tm_pkg;

    localparam int REG_W   = 32;
    localparam int B_EN    = 0;
    localparam int B_FRC   = 1;
    localparam int B_WVAL  = 2;
    localparam int B_SDI   = 3;
    localparam int B_CKW   = 4;
    localparam int B_CKR   = 5;
    localparam int B_CS_LO = 6;

    typedef struct packed {
        logic en;
        logic frc;
        logic wval;
        logic ckw;
    } tm_ctrl_t;

endpackage

// File: rtl/spi_tm_regs.sv
module spi_tm_regs
    import spi_tm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [REG_W-1:0] wdata,
    output tm_ctrl_t         ctrl
);

    tm_ctrl_t ctrl_d, ctrl_q;

    logic unused_wbits;
    assign unused_wbits = ^{wdata[REG_W-1:B_CKR], wdata[B_SDI]};

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr) begin
            ctrl_d.en   = wdata[B_EN];
            ctrl_d.frc  = wdata[B_FRC];
            ctrl_d.wval = wdata[B_WVAL];
            ctrl_d.ckw  = wdata[B_CKW];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    assign ctrl = ctrl_q;

endmodule

// File: rtl/spi_tm_sync.sv
module spi_tm_sync #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.s1 = din;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout = st_q.s2;

endmodule

// File: rtl/spi_tm_mux.sv
module spi_tm_mux
    import spi_tm_pkg::*;
(
    input  tm_ctrl_t ctrl,
    input  logic     func_sdo,
    input  logic     func_sclk,
    input  logic     pin_sdi,
    output logic     pad_sdo,
    output logic     pad_sclk,
    output logic     core_sdi
);

    always_comb begin
        pad_sdo  = func_sdo;
        pad_sclk = func_sclk;
        core_sdi = pin_sdi;
        if (ctrl.en) begin
            if (ctrl.frc) pad_sdo = ctrl.wval;
            pad_sclk = ctrl.ckw;
            core_sdi = pad_sdo;
        end
    end

endmodule

// File: rtl/spi_testmode_ctl.sv
module spi_testmode_ctl
    import spi_tm_pkg::*;
#(
    parameter int NCS = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             func_sdo,
    input  logic             func_sclk,
    output logic             core_sdi,
    input  logic             pin_sdi,
    input  logic [NCS-1:0]   pin_cs,
    output logic             pad_sdo,
    output logic             pad_sclk
);

    localparam int SW = NCS + 2;

    tm_ctrl_t      ctrl;
    logic [SW-1:0] sync_in, sync_out;
    logic          sdo_w, sclk_w, sdi_w;

    spi_tm_regs i_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (reg_wr),
        .wdata (reg_wdata),
        .ctrl  (ctrl)
    );

    spi_tm_mux i_mux (
        .ctrl      (ctrl),
        .func_sdo  (func_sdo),
        .func_sclk (func_sclk),
        .pin_sdi   (pin_sdi),
        .pad_sdo   (sdo_w),
        .pad_sclk  (sclk_w),
        .core_sdi  (sdi_w)
    );

    assign sync_in = {pin_cs, sclk_w, sdi_w};

    spi_tm_sync #(.W(SW)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (sync_in),
        .dout  (sync_out)
    );

    always_comb begin
        reg_rdata = '0;
        if (ctrl.en) begin
            reg_rdata[B_EN]                      = 1'b1;
            reg_rdata[B_FRC]                     = ctrl.frc;
            reg_rdata[B_WVAL]                    = ctrl.wval;
            reg_rdata[B_SDI]                     = sync_out[0];
            reg_rdata[B_CKW]                     = ctrl.ckw;
            reg_rdata[B_CKR]                     = sync_out[1];
            reg_rdata[B_CS_LO +: NCS]            = sync_out[SW-1:2];
        end
    end

    assign pad_sdo  = sdo_w;
    assign pad_sclk = sclk_w;
    assign core_sdi = sdi_w;

endmodule

// File: rtl/spi_tm_chk.sv
module spi_tm_chk
    import spi_tm_pkg::*;
#(
    parameter int NCS = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr,
    input logic [REG_W-1:0] reg_wdata,
    input logic [REG_W-1:0] reg_rdata,
    input logic             func_sdo,
    input logic             func_sclk,
    input logic             core_sdi,
    input logic             pin_sdi,
    input logic [NCS-1:0]   pin_cs,
    input logic             pad_sdo,
    input logic             pad_sclk
);

    logic [1:0] settle_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              settle_q <= '0;
        else if (settle_q != 2'd3) settle_q <= settle_q + 2'd1;
    end

    AST_OFF_WRITE_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr && !reg_wdata[B_EN] |=> reg_rdata == '0); // R2

    AST_ON_WRITE_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr && reg_wdata[B_EN] |=> reg_rdata[REG_W-1:B_CS_LO+NCS] == '0
            && reg_rdata[B_FRC] == $past(reg_wdata[B_FRC])
            && reg_rdata[B_WVAL] == $past(reg_wdata[B_WVAL])
            && reg_rdata[B_CKW] == $past(reg_wdata[B_CKW])); // R8

    AST_OFF_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rdata[B_EN] |-> pad_sdo == func_sdo && pad_sclk == func_sclk
            && core_sdi == pin_sdi); // R3

    AST_ON_LOOPBACK: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[B_EN] |-> core_sdi == pad_sdo); // R4

    AST_ON_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[B_EN] && reg_rdata[B_FRC] |-> pad_sdo == reg_rdata[B_WVAL]); // R5

    AST_ON_NOFORCE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[B_EN] && !reg_rdata[B_FRC] |-> pad_sdo == func_sdo); // R5

    AST_ON_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[B_EN] |-> pad_sclk == reg_rdata[B_CKW]); // R6

    AST_SYNC_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[B_EN] && settle_q >= 2'd2 |->
            reg_rdata[B_CKR] == $past(pad_sclk, 2)
            && reg_rdata[B_SDI] == $past(core_sdi, 2)
            && reg_rdata[B_CS_LO +: NCS] == $past(pin_cs, 2)); // R7

endmodule

bind spi_testmode_ctl spi_tm_chk #(.NCS(NCS)) i_chk (.*);

// File: tb/test_spi_testmode_ctl.sv
`timescale 1ns/1ps
module test_spi_testmode_ctl;

    localparam int NCS = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        func_sdo = 1'b0, func_sclk = 1'b0, pin_sdi = 1'b0;
    logic [NCS-1:0] pin_cs = '0;
    logic        core_sdi, pad_sdo, pad_sclk;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    spi_testmode_ctl #(.NCS(NCS)) i_spi_testmode_ctl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .func_sdo(func_sdo), .func_sclk(func_sclk),
        .core_sdi(core_sdi), .pin_sdi(pin_sdi), .pin_cs(pin_cs),
        .pad_sdo(pad_sdo), .pad_sclk(pad_sclk)
    );

    // behavioural reference: control bits plus a two-deep history queue
    bit m_en, m_frc, m_wv, m_ck;
    bit [NCS+1:0] hist[$];

    function automatic bit m_sdo();
        return (m_en && m_frc) ? m_wv : func_sdo;
    endfunction
    function automatic bit m_sclk();
        return m_en ? m_ck : func_sclk;
    endfunction
    function automatic bit m_sdi();
        return m_en ? m_sdo() : pin_sdi;
    endfunction
    function automatic logic [31:0] m_rd();
        logic [31:0] r;
        bit [NCS+1:0] old;
        r = '0;
        old = hist[0];
        if (m_en) begin
            r[0] = 1'b1; r[1] = m_frc; r[2] = m_wv; r[4] = m_ck;
            r[3] = old[0]; r[5] = old[1];
            r[6 +: NCS] = old[NCS+1:2];
        end
        return r;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_en = 0; m_frc = 0; m_wv = 0; m_ck = 0;
            hist = '{'0, '0};
        end else begin
            hist.push_back({pin_cs, m_sclk(), m_sdi()});
            void'(hist.pop_front());
            if (reg_wr) begin
                m_en = reg_wdata[0]; m_frc = reg_wdata[1];
                m_wv = reg_wdata[2]; m_ck = reg_wdata[4];
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk(m_en ? "R7 R8 rdata" : "R2 rdata", reg_rdata, m_rd());
        chk(m_en ? (m_frc ? "R5 pad_sdo" : "R5 pad_sdo nf") : "R3 pad_sdo",
            {31'b0, pad_sdo}, {31'b0, m_sdo()});
        chk(m_en ? "R6 pad_sclk" : "R3 pad_sclk", {31'b0, pad_sclk}, {31'b0, m_sclk()});
        chk(m_en ? "R4 core_sdi" : "R3 core_sdi", {31'b0, core_sdi}, {31'b0, m_sdi()});
    endtask

    // one cycle: check at the falling edge, then drive new inputs
    task automatic cycle(input bit wr, input logic [31:0] wd);
        @(negedge clk);
        compare_all();
        reg_wr    = wr;
        reg_wdata = wd;
        func_sdo  = 1'($urandom);
        func_sclk = 1'($urandom);
        pin_sdi   = 1'($urandom);
        pin_cs    = NCS'($urandom);
    endtask

    initial begin
        #20000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        hist = '{'0, '0};
        func_sdo = 1; func_sclk = 1; pin_sdi = 0;
        #12;
        // R1: reset state, pass-through of the functional signals
        chk("R1 rdata", reg_rdata, 32'h0);
        chk("R1 pad_sdo", {31'b0, pad_sdo}, 32'h1);
        chk("R1 pad_sclk", {31'b0, pad_sclk}, 32'h1);
        chk("R1 core_sdi", {31'b0, core_sdi}, 32'h0);
        @(negedge clk); rst_n = 1'b1;
        // R2/R3: test off, force/value bits set but ineffective
        for (int i = 0; i < 40; i++) cycle(i % 3 == 0, 32'hFFFF_FFFE);
        // R9: enable with force and value, observe next-cycle effect
        cycle(1'b1, 32'h0000_0017);
        cycle(1'b0, 32'h0);
        chk("R9 rdata after write", reg_rdata & 32'h17, 32'h17);
        // R8: write all ones while on; reserved and read-only bits ignored
        cycle(1'b1, 32'hFFFF_FFFF);
        for (int i = 0; i < 4; i++) cycle(1'b0, 32'h0);
        chk("R8 reserved", reg_rdata & 32'hFFFF_F800, 32'h0);
        // R4/R5/R6/R7: random traffic in test mode, force toggled
        for (int i = 0; i < 400; i++) begin
            bit w;
            logic [31:0] d;
            w = ($urandom % 4) == 0;
            d = $urandom;
            d[0] = ($urandom % 8) != 0;
            cycle(w, d);
        end
        // R5 no-force case held steady
        cycle(1'b1, 32'h0000_0001);
        for (int i = 0; i < 30; i++) cycle(1'b0, 32'h0);
        // back to off; R2/R3 again
        cycle(1'b1, 32'h0000_0016);
        for (int i = 0; i < 30; i++) cycle(1'b0, 32'h0);
        @(negedge clk);
        compare_all();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule